// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers 64 level-sensitive interrupt request lines and presents the CPU with one priority level and one vector number. Each source has an 8-bit control byte. A nonzero byte enables the source and is also its priority, and a zero byte switches the source off. A source takes part in arbitration when its line is pending or software has forced it, its control byte is nonzero, and its mask bit is clear. The source with the largest control byte wins. When two sources have the same byte, the one with the higher index wins.

Software reaches the block through a 32-bit register port that decodes byte offsets inside a 256-byte window. Each 64-bit state vector (pending, mask, force) occupies two words. The upper 32 bits are at the lower offset. Two command offsets set or clear a single mask bit, or the whole mask, without a read-modify-write. A read of the acknowledge offset returns the vector that is currently being presented. The level and vector outputs are registered. The reset input is asynchronous and active low, and an internal synchronizer releases it on a clock edge.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the mask reads all ones, the pending, force and control bytes read zero, `irq_level` is 0 and `irq_vector` is 24.
- R2: The pending bits copy `irq_lines` on every clock edge. Writes to the pending words at offsets 0x00 and 0x04 change nothing.
- R3: A source is active only when (pending or forced) and enabled and not masked.
- R4: The control byte of source i is at offset 0x40+i and takes `bus_wdata[7:0]`. A value of zero keeps the source out of arbitration, and any nonzero value enables it.
- R5: Among the active sources the winner is the one with the largest control byte. On equal bytes the higher source index wins.
- R6: `irq_level` equals the winner's control byte and `irq_vector` equals 64 plus the winner's index. With no active source the outputs are level 0 and vector 24.
- R7: A write to offset 0x1C sets the mask bit selected by `bus_wdata[5:0]`. When `bus_wdata[6]` is 1, all 64 mask bits are set instead.
- R8: A write to offset 0x1D clears the mask bit selected by `bus_wdata[5:0]`. When `bus_wdata[6]` is 1, the whole mask is cleared instead.
- R9: The mask words are at 0x08 (bits 63:32) and 0x0C (bits 31:0). The force words are at 0x10 (bits 63:32) and 0x14 (bits 31:0). The pending words are at 0x00 (bits 63:32) and 0x04 (bits 31:0). The mask and force words read back what was written.
- R10: `bus_rdata` is loaded on the clock edge that samples `bus_rd`. Offset 0xE0 returns the current `irq_vector` zero-extended, and any unmapped offset returns zero.
- R11: `irq_level` and `irq_vector` change on the clock edge after the edge that updates the register state.
- R12: A write to an offset outside {0x00, 0x04, 0x08, 0x0C, 0x10, 0x14, 0x1C, 0x1D, 0x40..0x7F} changes no state and raises `bus_wr_err` for exactly one cycle, on the edge after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 64 | Level-sensitive interrupt request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset inside the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_wr_err | output | 1 | One-cycle pulse after a write to an unmapped offset |
| irq_level | output | 8 | Priority level presented to the CPU |
| irq_vector | output | 8 | Vector number presented to the CPU |

## Verification
A register write takes effect on the edge that samples it, and the level and vector follow on the next edge. A change on an input line needs one more edge, because the pending register comes first. Read data and the error pulse both appear on the edge that samples the strobe. Stimulus is driven on falling edges, and the outputs are compared only after three further rising edges, which covers the longest path. A directed case samples the outputs at the falling edge between the write edge and the output edge, then one cycle later, to pin the exact one-cycle output delay.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned BUS_W   = 32;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned VEC_W   = 8;
  localparam int unsigned VEC_BASE = 64;
  localparam int unsigned VEC_IDLE = 24;
  localparam int unsigned ALL_BIT  = 6;

  localparam logic [ADDR_W-1:0] OFS_PEND_HI  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PEND_LO  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_MASK_HI  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_MASK_LO  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_FORCE_HI = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_FORCE_LO = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_MASK_SET = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 8'h1D;
  localparam logic [ADDR_W-1:0] OFS_VEC_ACK  = 8'hE0;
  localparam logic [1:0]        CTRL_WIN_TAG = 2'b01;
endpackage

// File: rtl/prio_irq_rst_sync.sv
module prio_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n = sync_q[STAGES-1];
endmodule

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned CTRL_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_SRC-1:0]        irq_lines,
  input  logic                      wr_en,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [BUS_W-1:0]          wdata,
  input  logic [VEC_W-1:0]          cur_vec,
  output logic [BUS_W-1:0]          rdata,
  output logic                      wr_err,
  output logic [NUM_SRC-1:0]        active,
  output logic [NUM_SRC*CTRL_W-1:0] ctrl_flat
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);
  localparam int unsigned HALF  = NUM_SRC / 2;

  logic [NUM_SRC-1:0] pend_q, mask_q, mask_d, force_q, force_d, enable;
  logic               mask_we, force_we, armed_q;
  logic [CTRL_W-1:0]  ctrl_q [NUM_SRC];
  logic [NUM_SRC-1:0] ctrl_we;
  logic [BUS_W-1:0]   rdata_d, rdata_q;
  logic               err_d, err_q;

  // Offset decode
  logic sel_pend_hi, sel_pend_lo, sel_mask_hi, sel_mask_lo;
  logic sel_force_hi, sel_force_lo, sel_mset, sel_mclr, sel_ctrl, sel_vec;
  logic wr_mapped;
  logic [IDX_W-1:0] ctrl_idx;

  always_comb begin
    sel_pend_hi  = (addr == OFS_PEND_HI);
    sel_pend_lo  = (addr == OFS_PEND_LO);
    sel_mask_hi  = (addr == OFS_MASK_HI);
    sel_mask_lo  = (addr == OFS_MASK_LO);
    sel_force_hi = (addr == OFS_FORCE_HI);
    sel_force_lo = (addr == OFS_FORCE_LO);
    sel_mset     = (addr == OFS_MASK_SET);
    sel_mclr     = (addr == OFS_MASK_CLR);
    sel_vec      = (addr == OFS_VEC_ACK);
    sel_ctrl     = (addr[ADDR_W-1:ADDR_W-2] == CTRL_WIN_TAG);
    ctrl_idx     = addr[IDX_W-1:0];
    wr_mapped    = sel_pend_hi | sel_pend_lo | sel_mask_hi | sel_mask_lo |
                   sel_force_hi | sel_force_lo | sel_mset | sel_mclr | sel_ctrl;
  end

  // Pending follows the request lines every cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= irq_lines;
  end

  // Mask next state: word writes and single/all set/clear commands
  always_comb begin
    mask_d  = mask_q;
    mask_we = 1'b0;
    if (wr_en) begin
      if (sel_mask_hi) begin
        mask_d[NUM_SRC-1:HALF] = wdata;
        mask_we = 1'b1;
      end
      if (sel_mask_lo) begin
        mask_d[HALF-1:0] = wdata;
        mask_we = 1'b1;
      end
      if (sel_mset) begin
        mask_we = 1'b1;
        if (wdata[ALL_BIT]) mask_d = '1;
        else                mask_d[wdata[IDX_W-1:0]] = 1'b1;
      end
      if (sel_mclr) begin
        mask_we = 1'b1;
        if (wdata[ALL_BIT]) mask_d = '0;
        else                mask_d[wdata[IDX_W-1:0]] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_we) mask_q <= mask_d;
  end

  // Force register: two word halves
  always_comb begin
    force_d  = force_q;
    force_we = 1'b0;
    if (wr_en && sel_force_hi) begin
      force_d[NUM_SRC-1:HALF] = wdata;
      force_we = 1'b1;
    end
    if (wr_en && sel_force_lo) begin
      force_d[HALF-1:0] = wdata;
      force_we = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        force_q <= '0;
    else if (force_we) force_q <= force_d;
  end

  // Per-source control bytes; nonzero byte enables the source
  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_ctrl
    assign ctrl_we[gi] = wr_en && sel_ctrl && (ctrl_idx == IDX_W'(gi));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           ctrl_q[gi] <= '0;
      else if (ctrl_we[gi]) ctrl_q[gi] <= wdata[CTRL_W-1:0];
    end

    assign ctrl_flat[gi*CTRL_W +: CTRL_W] = ctrl_q[gi];
    assign enable[gi] = |ctrl_q[gi];
  end

  assign active = (pend_q | force_q) & enable & ~mask_q;

  // Read mux, registered on the read strobe
  always_comb begin
    rdata_d = '0;
    if      (sel_pend_hi)  rdata_d = pend_q[NUM_SRC-1:HALF];
    else if (sel_pend_lo)  rdata_d = pend_q[HALF-1:0];
    else if (sel_mask_hi)  rdata_d = mask_q[NUM_SRC-1:HALF];
    else if (sel_mask_lo)  rdata_d = mask_q[HALF-1:0];
    else if (sel_force_hi) rdata_d = force_q[NUM_SRC-1:HALF];
    else if (sel_force_lo) rdata_d = force_q[HALF-1:0];
    else if (sel_ctrl)     rdata_d = {{(BUS_W-CTRL_W){1'b0}}, ctrl_q[ctrl_idx]};
    else if (sel_vec)      rdata_d = {{(BUS_W-VEC_W){1'b0}}, cur_vec};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rdata_d;
  end

  assign err_d = wr_en && !wr_mapped;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  assign rdata  = rdata_q;
  assign wr_err = err_q;

  AST_PEND_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
    pend_q == $past(irq_lines)) else $error("pending lost a line"); // R2

  AST_MASK_SET_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_mset && wdata[ALL_BIT]) |=> (mask_q == '1)) else $error("set-all failed"); // R7

  AST_MASK_CLR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel_mclr && wdata[ALL_BIT]) |=> (mask_q == '0)) else $error("clear-all failed"); // R8

  AST_BAD_WR_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_mapped) |=> ($stable(mask_q) && $stable(force_q) && $stable(ctrl_flat) && wr_err))
    else $error("unmapped write touched state"); // R12
endmodule

// File: rtl/prio_irq_resolver.sv
module prio_irq_resolver #(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned CTRL_W  = 8,
  localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
  input  logic [NUM_SRC-1:0]        active,
  input  logic [NUM_SRC*CTRL_W-1:0] ctrl_flat,
  output logic                      win_vld,
  output logic [CTRL_W-1:0]         win_pri,
  output logic [IDX_W-1:0]          win_idx
);
  localparam int unsigned NODES = 2*NUM_SRC - 1;
  localparam int unsigned FIRST_LEAF = NUM_SRC - 1;

  logic              nv [NODES];
  logic [CTRL_W-1:0] np [NODES];
  logic [IDX_W-1:0]  ni [NODES];

  // Leaves in ascending source order
  for (genvar gl = 0; gl < NUM_SRC; gl++) begin : g_leaf
    assign nv[FIRST_LEAF+gl] = active[gl];
    assign np[FIRST_LEAF+gl] = ctrl_flat[gl*CTRL_W +: CTRL_W];
    assign ni[FIRST_LEAF+gl] = IDX_W'(gl);
  end

  // Internal nodes: right child holds higher indices and wins ties
  for (genvar gn = 0; gn < NUM_SRC-1; gn++) begin : g_node
    logic take_hi;
    assign take_hi = nv[2*gn+2] && (!nv[2*gn+1] || (np[2*gn+2] >= np[2*gn+1]));
    assign nv[gn]  = nv[2*gn+1] | nv[2*gn+2];
    assign np[gn]  = take_hi ? np[2*gn+2] : np[2*gn+1];
    assign ni[gn]  = take_hi ? ni[2*gn+2] : ni[2*gn+1];
  end

  assign win_vld = nv[0];
  assign win_pri = np[0];
  assign win_idx = ni[0];

  // Cross-check the tree against a flat scan of the sources
  logic max_ok, tie_ok;
  always_comb begin
    max_ok = 1'b1;
    tie_ok = 1'b1;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (active[i] && (ctrl_flat[i*CTRL_W +: CTRL_W] > win_pri)) max_ok = 1'b0;
      if (active[i] && (ctrl_flat[i*CTRL_W +: CTRL_W] == win_pri) && (IDX_W'(i) > win_idx))
        tie_ok = 1'b0;
    end
    if (win_vld) begin
      AST_WIN_IS_ACTIVE: assert (active[win_idx]) else $error("winner not active"); // R3
      AST_WIN_ENABLED: assert (ctrl_flat[win_idx*CTRL_W +: CTRL_W] != '0) else $error("disabled winner"); // R4
      AST_WIN_IS_MAX: assert (max_ok) else $error("higher priority skipped"); // R5
      AST_TIE_TO_HIGH: assert (tie_ok) else $error("tie went to lower index"); // R5
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64,
  parameter int unsigned CTRL_W  = 8
) (
  input  logic               clk,
  input  logic               arst_n,
  input  logic [NUM_SRC-1:0] irq_lines,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  output logic               bus_wr_err,
  output logic [CTRL_W-1:0]  irq_level,
  output logic [VEC_W-1:0]   irq_vector
);
  localparam int unsigned IDX_W = $clog2(NUM_SRC);

  logic                      rst_n;
  logic [NUM_SRC-1:0]        active;
  logic [NUM_SRC*CTRL_W-1:0] ctrl_flat;
  logic                      win_vld;
  logic [CTRL_W-1:0]         win_pri;
  logic [IDX_W-1:0]          win_idx;
  logic [CTRL_W-1:0]         lvl_d, lvl_q;
  logic [VEC_W-1:0]          vec_d, vec_q;

  prio_irq_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk),
    .arst_n (arst_n),
    .rst_n  (rst_n)
  );

  prio_irq_regs #(.NUM_SRC(NUM_SRC), .CTRL_W(CTRL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_lines (irq_lines),
    .wr_en     (bus_wr),
    .rd_en     (bus_rd),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .cur_vec   (vec_q),
    .rdata     (bus_rdata),
    .wr_err    (bus_wr_err),
    .active    (active),
    .ctrl_flat (ctrl_flat)
  );

  prio_irq_resolver #(.NUM_SRC(NUM_SRC), .CTRL_W(CTRL_W)) u_res (
    .active    (active),
    .ctrl_flat (ctrl_flat),
    .win_vld   (win_vld),
    .win_pri   (win_pri),
    .win_idx   (win_idx)
  );

  always_comb begin
    lvl_d = '0;
    vec_d = VEC_W'(VEC_IDLE);
    if (win_vld) begin
      lvl_d = win_pri;
      vec_d = VEC_W'(VEC_BASE) + VEC_W'(win_idx);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      vec_q <= VEC_W'(VEC_IDLE);
    end else begin
      lvl_q <= lvl_d;
      vec_q <= vec_d;
    end
  end

  assign irq_level  = lvl_q;
  assign irq_vector = vec_q;

  AST_LEVEL_HAS_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_level != '0) |-> (irq_vector >= VEC_W'(VEC_BASE))) else $error("level without vector"); // R6

  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_vector == VEC_W'(VEC_IDLE)) |-> (irq_level == '0)) else $error("idle vector with level"); // R6
endmodule

// File: tb/sim_prio_irq_ctrl.sv
module sim_prio_irq_ctrl;
  localparam int PERIOD = 10;
  localparam int SEED   = 1357;

  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic [63:0] irq_lines = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_wr_err;
  logic [7:0]  irq_level, irq_vector;

  int checks = 0, failures = 0;

  // Model state
  logic [63:0] m_lines = '0, m_mask = '1, m_force = '0;
  logic [7:0]  m_ctrl [64];

  always #(PERIOD/2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .arst_n(arst_n), .irq_lines(irq_lines),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_wr_err(bus_wr_err),
    .irq_level(irq_level), .irq_vector(irq_vector)
  );

  function automatic logic [15:0] model_out();
    logic [7:0] best_lvl = 8'd0;
    logic [7:0] best_vec = 8'd24;
    for (int i = 0; i < 64; i++) begin
      if ((m_lines[i] | m_force[i]) && (m_ctrl[i] != 0) && !m_mask[i] && (m_ctrl[i] >= best_lvl)) begin
        best_lvl = m_ctrl[i];
        best_vec = 8'(64 + i);
      end
    end
    return {best_lvl, best_vec};
  endfunction

  function automatic logic [31:0] model_read(input logic [7:0] a);
    logic [15:0] o = model_out();
    if (a[7:6] == 2'b01) return {24'd0, m_ctrl[a[5:0]]};
    case (a)
      8'h00: return m_lines[63:32];
      8'h04: return m_lines[31:0];
      8'h08: return m_mask[63:32];
      8'h0C: return m_mask[31:0];
      8'h10: return m_force[63:32];
      8'h14: return m_force[31:0];
      8'hE0: return {24'd0, o[7:0]};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic model_mapped(input logic [7:0] a);
    return (a[7:6] == 2'b01) || a == 8'h00 || a == 8'h04 || a == 8'h08 || a == 8'h0C ||
           a == 8'h10 || a == 8'h14 || a == 8'h1C || a == 8'h1D;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [31:0] d);
    if (a[7:6] == 2'b01) m_ctrl[a[5:0]] = d[7:0];
    else case (a)
      8'h08: m_mask[63:32] = d;
      8'h0C: m_mask[31:0] = d;
      8'h10: m_force[63:32] = d;
      8'h14: m_force[31:0] = d;
      8'h1C: if (d[6]) m_mask = '1; else m_mask[d[5:0]] = 1'b1;
      8'h1D: if (d[6]) m_mask = '0; else m_mask[d[5:0]] = 1'b0;
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_check(input string tag, input logic [7:0] a);
    logic [31:0] d;
    logic [31:0] e = model_read(a);
    do_read(a, d);
    check(tag, d, e);
  endtask

  task automatic set_lines(input logic [63:0] v);
    @(negedge clk);
    irq_lines = v;
    m_lines = v;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic check_out(input string tag);
    logic [15:0] o = model_out();
    check({tag, " level"}, {24'd0, irq_level}, {24'd0, o[15:8]});
    check({tag, " vector"}, {24'd0, irq_vector}, {24'd0, o[7:0]});
  endtask

  task automatic check_pair(input string tag, input logic [7:0] lvl, input logic [7:0] vec);
    check({tag, " level"}, {24'd0, irq_level}, {24'd0, lvl});
    check({tag, " vector"}, {24'd0, irq_vector}, {24'd0, vec});
  endtask

  initial begin
    #(PERIOD * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] prev;
    for (int i = 0; i < 64; i++) m_ctrl[i] = 8'd0;
    void'($urandom(SEED));
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check_pair("R1 reset outputs", 8'd0, 8'd24);
    read_check("R1 mask hi", 8'h08);
    read_check("R1 mask lo", 8'h0C);
    read_check("R1 force hi", 8'h10);
    read_check("R1 force lo", 8'h14);
    read_check("R1 pend hi", 8'h00);
    read_check("R1 ctrl 5", 8'h45);

    // R4 zero control disables, nonzero enables
    set_lines(64'h20);
    do_write(8'h1D, 32'h40);
    settle();
    check_pair("R4 zero ctrl disables", 8'd0, 8'd24);
    do_write(8'h45, 32'h3);
    settle();
    check_pair("R4 R6 enabled source", 8'd3, 8'd69);

    // R7/R8 single mask bit; R3 masked source inactive
    do_write(8'h1C, 32'h05);
    settle();
    check_pair("R7 R3 masked source", 8'd0, 8'd24);
    read_check("R7 mask lo bit 5", 8'h0C);
    do_write(8'h1D, 32'h05);
    settle();
    check_pair("R8 unmasked source", 8'd3, 8'd69);

    // R5 ties and priority
    set_lines(64'h420);
    do_write(8'h4A, 32'h3);
    settle();
    check_pair("R5 tie to higher index", 8'd3, 8'd74);
    do_write(8'h45, 32'h7);
    settle();
    check_pair("R5 larger control wins", 8'd7, 8'd69);

    // R11 one-cycle output delay after a register write
    do_write(8'h4A, 32'h9);
    check_pair("R11 before output edge", 8'd7, 8'd69);
    @(negedge clk);
    check_pair("R11 after output edge", 8'd9, 8'd74);

    // R2 pending follows lines, pending writes ignored
    do_write(8'h04, 32'hFFFF_FFFF);
    do_write(8'h00, 32'hFFFF_FFFF);
    read_check("R2 pend lo after write", 8'h04);
    read_check("R2 pend hi after write", 8'h00);

    // R9 force words, upper half at lower offset
    set_lines(64'h0);
    do_write(8'h10, 32'h1);
    do_write(8'h60, 32'h2);
    settle();
    check_pair("R9 R3 forced source 32", 8'd2, 8'd96);
    read_check("R9 force hi", 8'h10);
    read_check("R9 force lo", 8'h14);
    do_write(8'h14, 32'h400);
    settle();
    check_pair("R9 forced source 10", 8'd9, 8'd74);
    do_write(8'h08, 32'h0000_0001);
    read_check("R9 mask hi word", 8'h08);
    do_write(8'h08, 32'h0);

    // R10 acknowledge readback and unmapped reads
    read_check("R10 vector ack", 8'hE0);
    read_check("R10 unmapped 0x30", 8'h30);
    read_check("R10 unmapped 0xE4", 8'hE4);

    // R12 unmapped write
    do_write(8'h18, 32'hFFFF_FFFF);
    check("R12 error pulse high", {31'd0, bus_wr_err}, 32'd1);
    @(negedge clk);
    check("R12 error pulse ends", {31'd0, bus_wr_err}, 32'd0);
    read_check("R12 mask hi unchanged", 8'h08);
    read_check("R12 force lo unchanged", 8'h14);
    settle();
    check_out("R12 outputs unchanged");

    // R7/R8 all-at-once
    do_write(8'h1C, 32'h40);
    settle();
    check_pair("R7 set all masks", 8'd0, 8'd24);
    read_check("R7 mask hi all ones", 8'h08);
    do_write(8'h1D, 32'h7F);
    read_check("R8 mask lo all zero", 8'h0C);
    settle();
    check_out("R8 all cleared outputs");

    // Random phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] a;
      logic [31:0] d;
      case (op)
        0, 1: set_lines({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
        2, 3, 4: begin
          a = 8'(8'h40 + $urandom_range(0, 63));
          d = ($urandom_range(0, 3) == 0) ? $urandom : 32'($urandom_range(0, 3));
          do_write(a, d);
        end
        5: do_write(8'h1C, 32'($urandom_range(0, 127)) & (($urandom_range(0, 7) == 0) ? 32'h7F : 32'h3F));
        6: do_write(8'h1D, 32'($urandom_range(0, 127)) & (($urandom_range(0, 5) == 0) ? 32'h7F : 32'h3F));
        7: do_write(($urandom_range(0, 1) == 0) ? 8'h10 : 8'h14, $urandom & $urandom);
        8: do_write(($urandom_range(0, 1) == 0) ? 8'h08 : 8'h0C, $urandom | $urandom);
        default: begin
          a = 8'($urandom);
          d = $urandom;
          prev = model_out();
          do_write(a, d);
          check("R12 random error flag", {31'd0, bus_wr_err}, {31'd0, !model_mapped(a)});
        end
      endcase
      settle();
      check_out("R5 R6 random");
      if (it % 8 == 0) begin
        logic [7:0] ra = ($urandom_range(0, 1) == 0) ? 8'(8'h40 + $urandom_range(0, 63))
                                                     : 8'($urandom_range(0, 7) * 4);
        read_check("R9 R10 random readback", ra);
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule